// File: doc/BRIEF.md
# Watchdog Guard with Reset or Non-Maskable Interrupt Action

The block is an 8-bit up-counter that guards against software lockup. Software arms it through a small control register, then has to write the counter back to zero at regular intervals. While it is armed, the counter advances by one on each cycle that the `tick` input is high. If software fails to reload it and it steps past 0xFF, the block takes one of two actions, chosen by a control bit. It either drives a chip-wide internal reset for a fixed number of clock cycles, or it issues a one-cycle non-maskable interrupt request.

A status bit records where the most recent reset came from. The external reset pin sets it to 1. The watchdog's own reset clears it to 0. When both happen at the same clock edge, the pin reset takes priority. The register port is plain: one write strobe with a one-bit address, and a combinational read mux. Nothing here carries a data stream, so there is no valid/ready handshake and no back-pressure. The pin reset `rst_pin_n` is active low and is sampled on the rising clock edge.

Top module: `wdt_guard`

## Requirements
- R1: While `rst_pin_n` is low at a clock edge, the control bits, counter and overflow flag become 0 and the source flag becomes 1. The control register (address 0) then reads 0x40 and the counter (address 1) reads 0x00. `sys_rst_out` and `nmi_req` are low.
- R2: The counter increments by one at an edge where `tick` is 1 and the run bit (control bit 0) is 1. Otherwise it holds its value.
- R3: A write to address 1 loads `wr_data` into the counter. This write takes precedence over a tick in the same cycle, so writing 0x00 while the counter holds 0xFF prevents any overflow action.
- R4: A tick while the counter is 0xFF and running wraps the counter to 0x00 and sets the overflow flag (control bit 7).
- R5: When control bit 1 (watchdog mode) and control bit 2 (reset action) are both 1, an overflow raises `sys_rst_out` from the cycle after the overflow edge. It stays high for exactly RST_LEN = 518 cycles.
- R6: Every edge while `sys_rst_out` is high clears the control bits, counter, overflow flag and source flag (bit 6) to 0. Register writes are ignored during this time.
- R7: In watchdog mode with control bit 2 at 0, an overflow gives a one-cycle `nmi_req` pulse in the following cycle. There is no reset, and the counter keeps running from 0x00.
- R8: With control bit 1 at 0 (interval mode), an overflow only sets the overflow flag. It produces neither `sys_rst_out` nor `nmi_req`.
- R9: If the pin reset and a reset-action overflow occur at the same edge, the pin reset wins. The source flag reads 1 and no internal reset pulse follows.
- R10: A write to address 0 with bit 7 at 0 clears the overflow flag. A write with bit 7 at 1 leaves the flag unchanged and never sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_pin_n | input | 1 | External reset pin, active low, sampled on the clock |
| tick | input | 1 | Count-enable pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 control, 1 counter |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Read address: 0 control/status, 1 counter |
| rd_data | output | 8 | Read data; control reads {ovf, src, 000, act, mode, run} |
| sys_rst_out | output | 1 | Internal reset produced by the watchdog |
| nmi_req | output | 1 | One-cycle non-maskable interrupt request |

## Verification
Two pairs of events can meet at the same clock edge. The first is the software reload and the final tick at 0xFF. The bench puts a zero write to the counter and a high `tick` in the same cycle while the counter holds 0xFF. It then expects a zero count with neither an internal reset nor an interrupt. The second is the pin reset and a reset-action overflow. The bench pulls the pin low in the very cycle the overflow tick arrives. It then judges by the source flag reading 1 and by `sys_rst_out` staying low afterwards.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;
  localparam int DATA_W   = 8;
  localparam int BIT_RUN  = 0;
  localparam int BIT_MODE = 1;
  localparam int BIT_ACT  = 2;
  localparam int BIT_SRC  = 6;
  localparam int BIT_OVF  = 7;

  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_CNT  = 1'b1
  } reg_sel_e;

  typedef struct packed {
    logic act_rst;
    logic wdog_mode;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_pin_n,
  input  logic         clr,
  input  logic         run,
  input  logic         tick,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] cnt_q,
  output logic         wrap
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  assign wrap = run && tick && !ld && !clr && (cnt_q == TOP);

  always_ff @(posedge clk) begin
    if (!rst_pin_n)       cnt_q <= '0;
    else if (clr)         cnt_q <= '0;
    else if (ld)          cnt_q <= ld_val;
    else if (run && tick) cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
  import wdt_guard_pkg::*;
(
  input  logic  clk,
  input  logic  rst_pin_n,
  input  logic  clr,
  input  logic  wr_ctrl,
  input  ctrl_t wr_bits,
  input  logic  keep_ovf,
  input  logic  wrap,
  output ctrl_t ctrl_q,
  output logic  ovf_q,
  output logic  src_q
);
  always_ff @(posedge clk) begin
    if (!rst_pin_n) begin
      ctrl_q <= '0;
      ovf_q  <= 1'b0;
      src_q  <= 1'b1;
    end else if (clr) begin
      ctrl_q <= '0;
      ovf_q  <= 1'b0;
      src_q  <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= wr_bits;
      if (wrap)                      ovf_q <= 1'b1;
      else if (wr_ctrl && !keep_ovf) ovf_q <= 1'b0;
    end
  end
endmodule

// File: rtl/wdt_rst_pulse.sv
module wdt_rst_pulse #(
  parameter int LEN = 518
) (
  input  logic clk,
  input  logic rst_pin_n,
  input  logic fire,
  output logic active
);
  localparam int RW = $clog2(LEN + 1);
  localparam logic [RW-1:0] LOAD = RW'(LEN);

  logic [RW-1:0] remain_q;

  assign active = (remain_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_pin_n)  remain_q <= '0;
    else if (fire)   remain_q <= LOAD;
    else if (active) remain_q <= remain_q - RW'(1);
  end
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_guard_pkg::*;
#(
  parameter int RST_LEN = 518
) (
  input  logic              clk,
  input  logic              rst_pin_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              sys_rst_out,
  output logic              nmi_req
);
  ctrl_t             ctrl_q;
  logic              ovf_q;
  logic              src_q;
  logic [DATA_W-1:0] cnt_q;
  logic              wrap;
  logic              wr_ctrl;
  logic              wr_cnt;
  logic              fire_rst;
  logic              fire_nmi;

  assign wr_ctrl  = wr_en && (reg_sel_e'(wr_addr) == SEL_CTRL) && !sys_rst_out;
  assign wr_cnt   = wr_en && (reg_sel_e'(wr_addr) == SEL_CNT)  && !sys_rst_out;
  assign fire_rst = wrap && ctrl_q.wdog_mode && ctrl_q.act_rst;
  assign fire_nmi = wrap && ctrl_q.wdog_mode && !ctrl_q.act_rst;

  wdt_count #(.W(DATA_W)) u_count (
    .clk       (clk),
    .rst_pin_n (rst_pin_n),
    .clr       (sys_rst_out),
    .run       (ctrl_q.run),
    .tick      (tick),
    .ld        (wr_cnt),
    .ld_val    (wr_data),
    .cnt_q     (cnt_q),
    .wrap      (wrap)
  );

  wdt_ctrl_reg u_ctrl (
    .clk       (clk),
    .rst_pin_n (rst_pin_n),
    .clr       (sys_rst_out),
    .wr_ctrl   (wr_ctrl),
    .wr_bits   (ctrl_t'(wr_data[BIT_ACT:BIT_RUN])),
    .keep_ovf  (wr_data[BIT_OVF]),
    .wrap      (wrap),
    .ctrl_q    (ctrl_q),
    .ovf_q     (ovf_q),
    .src_q     (src_q)
  );

  wdt_rst_pulse #(.LEN(RST_LEN)) u_pulse (
    .clk       (clk),
    .rst_pin_n (rst_pin_n),
    .fire      (fire_rst),
    .active    (sys_rst_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_pin_n) nmi_req <= 1'b0;
    else            nmi_req <= fire_nmi;
  end

  always_comb begin
    rd_data = '0;
    if (reg_sel_e'(rd_addr) == SEL_CNT) begin
      rd_data = cnt_q;
    end else begin
      rd_data[BIT_OVF]         = ovf_q;
      rd_data[BIT_SRC]         = src_q;
      rd_data[BIT_ACT:BIT_RUN] = ctrl_q;
    end
  end
endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk #(
  parameter int RST_LEN = 518
) (
  input logic       clk,
  input logic       rst_pin_n,
  input logic       tick,
  input logic       wr_en,
  input logic       wr_addr,
  input logic [7:0] wr_data,
  input logic       sys_rst_out,
  input logic       nmi_req,
  input logic [7:0] cnt_q,
  input logic [2:0] ctrl_bits,
  input logic       ovf_q,
  input logic       src_q
);
  localparam int LW = $clog2(RST_LEN + 2);
  logic [LW-1:0] run_len;

  always_ff @(posedge clk) begin
    if (!rst_pin_n)       run_len <= '0;
    else if (sys_rst_out) run_len <= run_len + LW'(1);
    else                  run_len <= '0;
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_pin_n)
    (!tick && !wr_en && !sys_rst_out) |=> $stable(cnt_q));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_pin_n)
    (wr_en && wr_addr && wr_data == 8'h00 && !sys_rst_out)
      |=> (cnt_q == 8'h00 && !nmi_req && !sys_rst_out));

  p_rst_len_r5: assert property (@(posedge clk) disable iff (!rst_pin_n)
    $fell(sys_rst_out) |-> (run_len == LW'(RST_LEN)));

  p_rst_clears_r6: assert property (@(posedge clk) disable iff (!rst_pin_n)
    sys_rst_out |=> (cnt_q == 8'h00 && ctrl_bits == 3'b000 && !ovf_q && !src_q));

  p_nmi_single_r7: assert property (@(posedge clk) disable iff (!rst_pin_n)
    nmi_req |=> !nmi_req);

  p_nmi_no_rst_r7: assert property (@(posedge clk) disable iff (!rst_pin_n)
    nmi_req |-> !sys_rst_out);
endmodule

bind wdt_guard wdt_guard_chk #(.RST_LEN(RST_LEN)) u_chk (
  .clk         (clk),
  .rst_pin_n   (rst_pin_n),
  .tick        (tick),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .sys_rst_out (sys_rst_out),
  .nmi_req     (nmi_req),
  .cnt_q       (cnt_q),
  .ctrl_bits   (ctrl_q),
  .ovf_q       (ovf_q),
  .src_q       (src_q)
);

// File: tb/wdt_guard_tb_top.sv
`timescale 1ns/1ps
module wdt_guard_tb_top;
  logic       clk = 1'b0;
  logic       rst_pin_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_addr = 1'b0;
  logic [7:0] rd_data;
  logic       sys_rst_out;
  logic       nmi_req;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  wdt_guard dut_i (
    .clk(clk), .rst_pin_n(rst_pin_n), .tick(tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .sys_rst_out(sys_rst_out), .nmi_req(nmi_req)
  );

  function automatic logic [7:0] next_cnt(logic [7:0] c, logic t, logic ld, logic [7:0] d);
    if (ld) return d;
    if (t)  return c + 8'd1;
    return c;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    tick  = 1'b0;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    rd_addr = a;
    #0.5;
    v = rd_data;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      summary();
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] exp_cnt;
    int n;
    void'($urandom(32'd2024));
    repeat (4) step();
    rst_pin_n = 1'b1;
    step();

    // R1 reset state
    rd(1'b0, v); chk("R1 ctrl", v, 8'h40);
    rd(1'b1, v); chk("R1 cnt", v, 8'h00);
    chk("R1 sys_rst", sys_rst_out, 0);
    chk("R1 nmi", nmi_req, 0);

    // R2 no count while run bit is 0
    tick = 1'b1; step();
    rd(1'b1, v); chk("R2 idle", v, 8'h00);

    // R2 count with ticks, gaps hold
    wr(1'b0, 8'h07);
    for (int i = 0; i < 10; i++) begin
      tick = (i % 2 == 0);
      step();
    end
    rd(1'b1, v); chk("R2 count", v, 8'd5);

    // R3 random reload traffic, never overflowing
    exp_cnt = 8'd5;
    for (int i = 0; i < 400; i++) begin
      logic t, we;
      logic [7:0] d;
      t  = 1'($urandom % 2);
      we = ($urandom % 8 == 0) || (exp_cnt >= 8'hF0);
      d  = (exp_cnt >= 8'hF0) ? 8'h00 : 8'($urandom % 8'hF0);
      tick = t; wr_en = we; wr_addr = 1'b1; wr_data = d;
      exp_cnt = next_cnt(exp_cnt, t, we, d);
      step();
      rd(1'b1, v); chk("R3 random cnt", v, exp_cnt);
      chk("R3 random no rst", sys_rst_out, 0);
    end

    // R3 corner: reload and final tick in the same cycle
    wr(1'b1, 8'hFF);
    tick = 1'b1; wr_en = 1'b1; wr_addr = 1'b1; wr_data = 8'h00;
    step();
    rd(1'b1, v); chk("R3 same-cycle reload", v, 8'h00);
    chk("R3 no rst", sys_rst_out, 0);
    chk("R3 no nmi", nmi_req, 0);
    rd(1'b0, v); chk("R3 no ovf", v[7], 0);

    // R4 R5 R6 reset-action overflow
    wr(1'b1, 8'hFF);
    tick = 1'b1; step();
    chk("R5 rst rises", sys_rst_out, 1);
    rd(1'b0, v); chk("R4 ovf set", v[7], 1);
    rd(1'b1, v); chk("R4 wrap", v, 8'h00);
    n = 0;
    while (sys_rst_out && n < 2000) begin
      n++;
      if (n == 3) begin
        rd(1'b0, v); chk("R6 ctrl cleared", v, 8'h00);
      end
      if (n == 4) begin
        wr_en = 1'b1; wr_addr = 1'b0; wr_data = 8'h07;
      end
      if (n == 5) begin
        wr_en = 1'b1; wr_addr = 1'b1; wr_data = 8'h33;
      end
      step();
    end
    chk("R5 pulse length", n, 518);
    rd(1'b0, v); chk("R6 write ignored ctrl", v, 8'h00);
    rd(1'b1, v); chk("R6 write ignored cnt", v, 8'h00);

    // R7 NMI action
    wr(1'b0, 8'h03);
    wr(1'b1, 8'hFF);
    tick = 1'b1; step();
    chk("R7 nmi pulse", nmi_req, 1);
    chk("R7 no rst", sys_rst_out, 0);
    rd(1'b0, v); chk("R4 ovf nmi", v, 8'h83);
    tick = 1'b1; step();
    chk("R7 nmi single", nmi_req, 0);
    rd(1'b1, v); chk("R7 keeps counting", v, 8'h01);

    // R10 overflow flag clearing
    wr(1'b0, 8'h83);
    rd(1'b0, v); chk("R10 write1 keeps", v, 8'h83);
    wr(1'b0, 8'h03);
    rd(1'b0, v); chk("R10 write0 clears", v, 8'h03);
    wr(1'b0, 8'h83);
    rd(1'b0, v); chk("R10 write1 no set", v, 8'h03);

    // R8 interval mode
    wr(1'b0, 8'h05);
    wr(1'b1, 8'hFF);
    tick = 1'b1; step();
    chk("R8 no nmi", nmi_req, 0);
    chk("R8 no rst", sys_rst_out, 0);
    rd(1'b0, v); chk("R8 ovf", v, 8'h85);
    repeat (3) step();
    chk("R8 still no rst", sys_rst_out, 0);

    // R9 pin reset coincides with overflow
    wr(1'b0, 8'h07);
    wr(1'b1, 8'hFF);
    tick = 1'b1; rst_pin_n = 1'b0;
    step();
    rst_pin_n = 1'b1;
    chk("R9 no rst", sys_rst_out, 0);
    rd(1'b0, v); chk("R9 src", v, 8'h40);
    repeat (3) step();
    chk("R9 still no rst", sys_rst_out, 0);
    rd(1'b1, v); chk("R9 cnt", v, 8'h00);

    done = 1'b1;
    summary();
  end
endmodule